// File: doc/BRIEF.md
# Polynomial-Division Signature Register

This block compacts the response of a circuit under self-test into a short signature. It treats the incoming stream as the coefficients of a dividend polynomial and divides it, one step per clock, by a programmable characteristic polynomial of degree k. The divider is a shift register with an XOR gate in front of each stage, and the rightmost stage feeds back into every stage whose tap is set. The bits leaving the rightmost stage are the quotient. The register contents at the end are the remainder, and that remainder is the signature.

There are two ways to feed the register. In serial mode one bit per clock enters the leftmost stage, highest-order coefficient first. In parallel mode a k-bit response word is XORed into all stages at once, one bit per stage. A synchronous clear zeroes the register. A start pulse opens a test window. A done pulse closes it, freezes the signature and records whether it matches a programmed known-good value. With a k-bit signature the chance that a faulty response aliases to the good signature is about 2^-k. k defaults to 16.

Top module: `poly_sig_reg`

## Requirements
- R1: After reset, sig_o, quot_o, running_o, verdict_valid_o and pass_o are all 0.
- R2: Each clock inside the window, with serial mode selected (mode_i = 0), the register updates as follows. Call the old rightmost stage fb, which is bit k-1. Then stage 0 becomes bit_i XOR (taps_i[0] AND fb), and each stage j > 0 becomes old stage j-1 XOR (taps_i[j] AND fb). Bit j of taps_i is the coefficient of x^j, and x^k is implicit. Example: taps 3'b011 (x^3+x+1) with stream 1001011 from a zero start leaves remainder 3'b101.
- R3: After each shift, quot_o holds the bit that was in stage k-1 before that shift. For the example in R2, the seven quotient bits are 0001010.
- R4: With parallel mode selected (mode_i = 1), bit j of word_i is also XORed into stage j on each shift, and bit_i has no effect. In serial mode word_i has no effect.
- R5: A start_i pulse while idle raises running_o one cycle later. Shifting happens only on cycles where running_o is 1 and done_i is 0. At all other times sig_o and quot_o hold their values.
- R6: done_i while running ends the window without a shift on that cycle. On the next cycle running_o is 0, verdict_valid_o is 1, and pass_o is 1 exactly when sig_o equals expect_i.
- R7: clear_i zeroes the signature, quot_o, the window and the verdict on the next cycle. It takes priority over start_i and done_i.
- R8: start_i while running and done_i while idle have no effect. An accepted start_i clears verdict_valid_o and pass_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of register, window and verdict |
| start_i | input | 1 | Opens a test window |
| done_i | input | 1 | Closes the window and latches the verdict |
| mode_i | input | 1 | 0 serial feed, 1 parallel feed |
| bit_i | input | 1 | Serial dividend bit |
| word_i | input | WIDTH | Parallel response word |
| taps_i | input | WIDTH | Polynomial coefficients x^0..x^(k-1) |
| expect_i | input | WIDTH | Known-good signature |
| sig_o | output | WIDTH | Remainder (signature) |
| quot_o | output | 1 | Last quotient bit shifted out |
| running_o | output | 1 | Test window open |
| verdict_valid_o | output | 1 | A verdict has been latched |
| pass_o | output | 1 | Latched signature matched expect_i |

## Verification
The hardest case to reach from the ports is the exact division result: a quotient and a remainder that can be checked by hand. A wide register gives no such hand-checkable numbers, so the bench also builds a three-stage instance, programs it with x^3+x+1 and feeds it a short stream whose quotient and remainder are known. At the same time, the default-width instance is checked against a behavioural remainder update on every cycle of long serial and parallel runs. The bench also drives done and start pulses at the edges of the window, and clears in the middle of a window, to show that these pulses have no side effects.

// File: rtl/sigreg_pkg.sv
package sigreg_pkg;
  typedef enum logic {FEED_SERIAL = 1'b0, FEED_PARALLEL = 1'b1} feed_mode_e;
  typedef enum logic {WIN_IDLE = 1'b0, WIN_RUN = 1'b1} win_state_e;
endpackage

// File: rtl/sigreg_divider.sv
module sigreg_divider import sigreg_pkg::*; #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             shift_i,
  input  logic             mode_i,
  input  logic             bit_i,
  input  logic [WIDTH-1:0] word_i,
  input  logic [WIDTH-1:0] taps_i,
  output logic [WIDTH-1:0] rem_o,
  output logic             quot_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] rem_q, rem_d;
  logic             quot_q, fb;
  feed_mode_e       feed;

  assign feed = feed_mode_e'(mode_i);
  assign fb   = rem_q[MSB];

  for (genvar j = 0; j < WIDTH; j++) begin : g_stage
    if (j == 0) begin : g_head
      logic carry;
      assign carry    = (feed == FEED_PARALLEL) ? word_i[0] : bit_i;
      assign rem_d[j] = carry ^ (taps_i[j] & fb);
    end else begin : g_body
      logic carry;
      assign carry    = rem_q[j-1] ^ (word_i[j] & (feed == FEED_PARALLEL));
      assign rem_d[j] = carry ^ (taps_i[j] & fb);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quot_q <= 1'b0;
    end else if (clear_i) begin
      rem_q  <= '0;
      quot_q <= 1'b0;
    end else if (shift_i) begin
      rem_q  <= rem_d;
      quot_q <= fb;
    end
  end

  assign rem_o  = rem_q;
  assign quot_o = quot_q;

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && !clear_i) |=> ($stable(rem_q) && $stable(quot_q)));
  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (rem_q == '0 && !quot_q));
  assert_quot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !clear_i) |=> (quot_q == $past(rem_q[MSB])));
endmodule

// File: rtl/sigreg_window.sv
module sigreg_window import sigreg_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic start_i,
  input  logic done_i,
  output logic shift_o,
  output logic capture_o,
  output logic launch_o,
  output logic running_o
);
  win_state_e win_q;

  always_comb begin
    shift_o   = (win_q == WIN_RUN) && !done_i && !clear_i;
    capture_o = (win_q == WIN_RUN) && done_i && !clear_i;
    launch_o  = (win_q == WIN_IDLE) && start_i && !clear_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        win_q <= WIN_IDLE;
    else if (clear_i)   win_q <= WIN_IDLE;
    else if (capture_o) win_q <= WIN_IDLE;
    else if (launch_o)  win_q <= WIN_RUN;
  end

  assign running_o = (win_q == WIN_RUN);

  assert_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running_o && start_i && !clear_i) |=> running_o);
  assert_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && done_i) |=> !running_o);
  assert_idle_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running_o && !start_i) |=> !running_o);
endmodule

// File: rtl/sigreg_verdict.sv
module sigreg_verdict #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             launch_i,
  input  logic             capture_i,
  input  logic [WIDTH-1:0] rem_i,
  input  logic [WIDTH-1:0] expect_i,
  output logic             valid_o,
  output logic             pass_o
);
  logic valid_q, pass_q, match;

  assign match = (rem_i == expect_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      pass_q  <= 1'b0;
    end else if (clear_i || launch_i) begin
      valid_q <= 1'b0;
      pass_q  <= 1'b0;
    end else if (capture_i) begin
      valid_q <= 1'b1;
      pass_q  <= match;
    end
  end

  assign valid_o = valid_q;
  assign pass_o  = pass_q;

  assert_pass_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_q |-> valid_q);
  assert_capture_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_i && !clear_i) |=> valid_q);
  assert_launch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_i || clear_i) |=> (!valid_q && !pass_q));
endmodule

// File: rtl/poly_sig_reg.sv
module poly_sig_reg #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             start_i,
  input  logic             done_i,
  input  logic             mode_i,
  input  logic             bit_i,
  input  logic [WIDTH-1:0] word_i,
  input  logic [WIDTH-1:0] taps_i,
  input  logic [WIDTH-1:0] expect_i,
  output logic [WIDTH-1:0] sig_o,
  output logic             quot_o,
  output logic             running_o,
  output logic             verdict_valid_o,
  output logic             pass_o
);
  logic shift, capture, launch;

  sigreg_window u_window (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear_i),
    .start_i  (start_i),
    .done_i   (done_i),
    .shift_o  (shift),
    .capture_o(capture),
    .launch_o (launch),
    .running_o(running_o)
  );

  sigreg_divider #(.WIDTH(WIDTH)) u_divider (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear_i),
    .shift_i(shift),
    .mode_i (mode_i),
    .bit_i  (bit_i),
    .word_i (word_i),
    .taps_i (taps_i),
    .rem_o  (sig_o),
    .quot_o (quot_o)
  );

  sigreg_verdict #(.WIDTH(WIDTH)) u_verdict (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear_i),
    .launch_i (launch),
    .capture_i(capture),
    .rem_i    (sig_o),
    .expect_i (expect_i),
    .valid_o  (verdict_valid_o),
    .pass_o   (pass_o)
  );

  assert_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running_o && !clear_i) |=> $stable(sig_o));
endmodule

// File: tb/poly_sig_reg_tb_top.sv
`timescale 1ns/1ps
module poly_sig_reg_tb_top;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic clear = 0, start = 0, done = 0, mode = 0, bit_in = 0;
  logic [W-1:0] word = '0, taps = 16'h1021, expv = '0;
  logic [2:0] taps3 = 3'b011, expv3 = 3'b101;

  logic [W-1:0] sig;
  logic quot, running, vvalid, pass;
  logic [2:0] sig3;
  logic quot3, running3, vvalid3, pass3;

  int n_checks = 0, n_fail = 0;
  bit cmp_on = 0, finished = 0;
  string cur_req = "R1";

  // behavioural reference: remainder update r = r*x + in mod P
  logic [W-1:0] m_sig;
  logic m_quot, m_run, m_val, m_pass;

  always #4 clk = ~clk;

  poly_sig_reg #(.WIDTH(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear), .start_i(start), .done_i(done),
    .mode_i(mode), .bit_i(bit_in), .word_i(word), .taps_i(taps), .expect_i(expv),
    .sig_o(sig), .quot_o(quot), .running_o(running), .verdict_valid_o(vvalid), .pass_o(pass));

  poly_sig_reg #(.WIDTH(3)) dut_k3_i (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear), .start_i(start), .done_i(done),
    .mode_i(mode), .bit_i(bit_in), .word_i(word[2:0]), .taps_i(taps3), .expect_i(expv3),
    .sig_o(sig3), .quot_o(quot3), .running_o(running3), .verdict_valid_o(vvalid3), .pass_o(pass3));

  function automatic logic [W-1:0] divide_step(logic [W-1:0] r, logic m, logic b,
                                               logic [W-1:0] w, logic [W-1:0] p);
    logic [W-1:0] n;
    n = m ? ((r << 1) ^ w) : ((r << 1) | W'(b));
    if (r[W-1]) n = n ^ p;
    return n;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_sig <= '0; m_quot <= 0; m_run <= 0; m_val <= 0; m_pass <= 0;
    end else if (clear) begin
      m_sig <= '0; m_quot <= 0; m_run <= 0; m_val <= 0; m_pass <= 0;
    end else if (m_run && done) begin
      m_run <= 0; m_val <= 1; m_pass <= (m_sig == expv);
    end else if (m_run) begin
      m_quot <= m_sig[W-1];
      m_sig  <= divide_step(m_sig, mode, bit_in, word, taps);
    end else if (start) begin
      m_run <= 1; m_val <= 0; m_pass <= 0;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_ni) begin
      chk(cur_req, "sig", 32'(sig), 32'(m_sig));
      chk(cur_req, "quot", 32'(quot), 32'(m_quot));
      chk(cur_req, "running", 32'(running), 32'(m_run));
      chk(cur_req, "valid", 32'(vvalid), 32'(m_val));
      chk(cur_req, "pass", 32'(pass), 32'(m_pass));
    end
  end

  task automatic step(logic s, logic d, logic c, logic b, logic [W-1:0] w);
    @(negedge clk);
    start = s; done = d; clear = c; bit_in = b; word = w;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [6:0] stream;
    logic [6:0] qs;
    logic [W-1:0] held;
    stream = 7'b1001011;
    qs = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "sig", 32'(sig), 0);
    chk("R1", "quot", 32'(quot), 0);
    chk("R1", "running", 32'(running), 0);
    chk("R1", "valid/pass", 32'({vvalid, pass}), 0);
    rst_ni = 1;
    cmp_on = 1;

    // R2/R3 hand-checked division on the k=3 instance
    cur_req = "R2";
    step(0, 0, 1, 0, '0);
    step(1, 0, 0, 0, '0);
    for (int i = 0; i < 8; i++) begin
      step(0, i == 7, 0, (i < 7) ? stream[6-i] : 1'b0, '0);
      if (i > 0) qs = {qs[5:0], quot3};
    end
    step(0, 0, 0, 0, '0);
    chk("R3", "quotient stream k3", 32'(qs), 32'(7'b0001010));
    chk("R2", "remainder k3", 32'(sig3), 32'(3'b101));
    chk("R6", "k3 verdict valid+pass", 32'({vvalid3, pass3}), 32'(2'b11));

    // R2 long serial run, golden programmed from reference -> pass; word toggles ignored (R4)
    cur_req = "R4";
    taps = 16'h8005;
    step(0, 0, 1, 0, '0);
    step(1, 0, 0, 0, '0);
    for (int i = 0; i < 200; i++) step(0, 0, 0, 1'($urandom), W'($urandom));
    @(negedge clk); expv = m_sig; start = 0; done = 1; bit_in = 0;
    step(0, 0, 0, 0, '0);
    chk("R6", "serial run pass", 32'({vvalid, pass}), 32'(2'b11));

    // R8 done while idle ignored, start clears verdict
    cur_req = "R8";
    step(0, 1, 0, 0, '0);
    step(0, 0, 0, 0, '0);
    chk("R8", "idle done keeps verdict", 32'({running, vvalid, pass}), 32'(3'b011));

    // R4 parallel mode, bit_i ignored; wrong golden -> fail
    cur_req = "R4";
    mode = 1;
    step(1, 0, 0, 0, '0);
    step(0, 0, 0, 0, '0);
    chk("R8", "start clears verdict", 32'({running, vvalid}), 32'(2'b10));
    step(1, 0, 0, 1, 16'hA5A5); // start while running ignored
    for (int i = 0; i < 150; i++) step(0, 0, 0, 1'($urandom), W'($urandom));
    @(negedge clk); expv = ~m_sig; start = 0; done = 1;
    step(0, 0, 0, 0, '0);
    chk("R6", "mismatch fails", 32'({vvalid, pass}), 32'(2'b10));

    // R5 idle hold under busy inputs
    cur_req = "R5";
    held = sig;
    for (int i = 0; i < 20; i++) step(0, 0, 0, 1'($urandom), W'($urandom));
    chk("R5", "idle holds sig", 32'(sig), 32'(held));

    // R7 clear mid-window, beats start and done
    cur_req = "R7";
    mode = 0; taps = 16'h1021;
    step(1, 0, 0, 0, '0);
    for (int i = 0; i < 30; i++) step(0, 0, 0, 1'($urandom), '0);
    step(1, 1, 1, 1, '1);
    step(0, 0, 0, 0, '0);
    chk("R7", "clear zeroes all", 32'({sig, quot, running, vvalid, pass}), 0);

    // R2 single-one impulse through default width
    cur_req = "R2";
    step(1, 0, 0, 0, '0);
    step(0, 0, 0, 1, '0);
    for (int i = 0; i < W; i++) step(0, 0, 0, 0, '0);
    step(0, 0, 0, 0, '0);
    chk("R2", "impulse wraps to taps", 32'(sig), 32'(16'h1021));
    step(0, 1, 0, 0, '0);
    step(0, 0, 0, 0, '0);
    step(0, 0, 0, 0, '0);
    finish_run();
  end
endmodule